// File: doc/BRIEF.md
# Dual-Width Register File

This block is the working-register store of a small processor core. It holds thirty-two 8-bit registers. Two operand ports read combinationally and one write port commits on the rising clock edge, so any read or write finishes within one cycle. Besides single-byte access, the file treats an even/odd register couple as one 16-bit quantity. The even member carries the low byte and the odd member carries the high byte. Such a couple can be read as one operand or written as one result in a single cycle.

The datapath controller picks one of four access schemes each cycle with `mode_sel`:
- 0: one byte operand and a byte result.
- 1: two byte operands and a byte result.
- 2: two byte operands and a 16-bit result into a couple.
- 3: a 16-bit couple operand and a 16-bit couple result.

A couple index must be even. An odd index raises `pair_err`, and the offending access is neutralised.

Top module: `dwrf_core`

## Requirements
- R1: While `rst_n` is low, every register reads as 0x00.
- R2: In modes 0 and 1 with `wr_en` high, the rising edge stores `wr_data[7:0]` into register `wr_addr` and leaves all other registers unchanged.
- R3: In mode 0, `op_a` = {8'h00, reg[`ra_addr`]} and `op_b` = 0.
- R4: In modes 1 and 2, `op_a` = {8'h00, reg[`ra_addr`]} and `op_b` = {8'h00, reg[`rb_addr`]}.
- R5: In modes 2 and 3 with `wr_en` high and an even `wr_addr`, one edge stores `wr_data[7:0]` into reg[`wr_addr`] and `wr_data[15:8]` into reg[`wr_addr`+1].
- R6: In mode 3 with an even `ra_addr`, `op_a` = {reg[`ra_addr`+1], reg[`ra_addr`]} and `op_b` = 0.
- R7: `pair_err` is high when either of these holds: (mode 2 or 3) with `wr_en` high and `wr_addr[0]`=1, or mode 3 with `ra_addr[0]`=1. A couple write with an odd index changes no register. A couple read with an odd index gives `op_a` = 0.
- R8: When a read address equals the write address in the same cycle, the read returns the value held before that edge.
- R9: With `wr_en` low, no register changes at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Access scheme, 0..3 |
| ra_addr | input | 5 | Operand A register or couple index |
| rb_addr | input | 5 | Operand B register index |
| wr_en | input | 1 | Write commit enable |
| wr_addr | input | 5 | Destination register or couple index |
| wr_data | input | 16 | Result; low byte only in byte-write modes |
| op_a | output | 16 | Operand A, byte zero-extended or couple |
| op_b | output | 16 | Operand B, byte zero-extended or zero |
| pair_err | output | 1 | Odd couple index seen this cycle |

## Verification
Some properties are checked every cycle by the assertions:
- Registers hold when not enabled.
- A byte write enables exactly one register.
- A couple write lands both bytes on one edge.
- An odd-index couple write leaves the whole file still.
- Operand B is silent in the schemes that do not use it.
- Reset clears the file.

The bench's scenarios show what a cycle-local property cannot. A reference model checks that operand values follow a long history of mixed byte and couple writes. The bench also confirms that a same-cycle read sees the pre-edge value, and that a couple written in one scheme reads back correctly in another.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;

  typedef enum logic [1:0] {
    ACC_ONE_BYTE   = 2'd0,
    ACC_TWO_BYTE   = 2'd1,
    ACC_TWO_PAIRWR = 2'd2,
    ACC_PAIR_BOTH  = 2'd3
  } acc_mode_e;

  function automatic logic is_pair_write(input acc_mode_e m);
    return (m == ACC_TWO_PAIRWR) || (m == ACC_PAIR_BOTH);
  endfunction

  function automatic logic is_pair_read(input acc_mode_e m);
    return m == ACC_PAIR_BOTH;
  endfunction

  function automatic logic uses_port_b(input acc_mode_e m);
    return (m == ACC_TWO_BYTE) || (m == ACC_TWO_PAIRWR);
  endfunction

endpackage

// File: rtl/dwrf_wr_decode.sv
module dwrf_wr_decode
  import dwrf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  acc_mode_e                mode,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [2*DW-1:0]          wr_data,
  output logic [NREGS-1:0]         we_vec,
  output logic [NREGS-1:0][DW-1:0] wd_vec,
  output logic                     wr_odd_pair
);

  logic pair_wr;
  logic commit;

  assign pair_wr     = is_pair_write(mode);
  assign wr_odd_pair = wr_en && pair_wr && wr_addr[0];
  assign commit      = wr_en && !wr_odd_pair;

  for (genvar i = 0; i < NREGS; i++) begin : g_slot
    localparam logic [AW-1:0] IDX = AW'(i);
    logic hit_byte;
    logic hit_pair;
    assign hit_byte  = (wr_addr == IDX);
    assign hit_pair  = (wr_addr[AW-1:1] == IDX[AW-1:1]);
    assign we_vec[i] = commit && (pair_wr ? hit_pair : hit_byte);
    if (i % 2 == 1) begin : g_odd
      assign wd_vec[i] = pair_wr ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
    end else begin : g_even
      assign wd_vec[i] = wr_data[DW-1:0];
    end
  end

  // R2: a byte write enables one register
  p_one_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pair_wr) |-> ($countones(we_vec) == 1));

  // R5: a couple write enables exactly two registers
  p_two_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pair_wr && !wr_addr[0]) |-> ($countones(we_vec) == 2));

  // R9: no enable without a commit request
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (we_vec == '0));

endmodule

// File: rtl/dwrf_store.sv
module dwrf_store #(
  parameter int NREGS = 32,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREGS-1:0]         we_vec,
  input  logic [NREGS-1:0][DW-1:0] wd_vec,
  output logic [NREGS-1:0][DW-1:0] rf_q
);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rf_q[i] <= '0;
      else if (we_vec[i]) rf_q[i] <= wd_vec[i];
    end

    // R9: an unenabled register keeps its value
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_vec[i] |=> $stable(rf_q[i]));
  end

  // R1: reset leaves the file clear
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (rf_q == '0));

endmodule

// File: rtl/dwrf_rd_port.sv
module dwrf_rd_port
  import dwrf_pkg::*;
#(
  parameter int NREGS        = 32,
  parameter int DW           = 8,
  parameter bit PAIR_CAPABLE = 1'b1,
  localparam int AW          = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  acc_mode_e                mode,
  input  logic [NREGS-1:0][DW-1:0] rf_q,
  input  logic [AW-1:0]            addr,
  output logic [2*DW-1:0]          rd,
  output logic                     odd_pair
);

  function automatic logic [2*DW-1:0] join_bytes(input logic [DW-1:0] hi,
                                                 input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

  logic [DW-1:0] byte_sel;
  assign byte_sel = rf_q[addr];

  if (PAIR_CAPABLE) begin : g_pair
    logic [AW-1:0] hi_idx;
    assign hi_idx   = {addr[AW-1:1], 1'b1};
    assign odd_pair = is_pair_read(mode) && addr[0];
    always_comb begin
      if (is_pair_read(mode))
        rd = odd_pair ? '0 : join_bytes(rf_q[hi_idx], byte_sel);
      else
        rd = join_bytes('0, byte_sel);
    end

    // R7: an odd couple read yields nothing
    p_odd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      odd_pair |-> (rd == '0));
  end else begin : g_byte
    assign odd_pair = 1'b0;
    assign rd = uses_port_b(mode) ? join_bytes('0, byte_sel) : '0;

    // R3: second port is silent when the scheme leaves it unused
    p_b_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !uses_port_b(mode) |-> (rd == '0));
  end

endmodule

// File: rtl/dwrf_core.sv
module dwrf_core
  import dwrf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic [AW-1:0]   ra_addr,
  input  logic [AW-1:0]   rb_addr,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*DW-1:0] wr_data,
  output logic [2*DW-1:0] op_a,
  output logic [2*DW-1:0] op_b,
  output logic            pair_err
);

  acc_mode_e                mode;
  logic [NREGS-1:0]         we_vec;
  logic [NREGS-1:0][DW-1:0] wd_vec;
  logic [NREGS-1:0][DW-1:0] rf_q;
  logic                     wr_odd_pair;
  logic                     rd_odd_pair;
  logic                     b_unused_err;

  assign mode = acc_mode_e'(mode_sel);

  dwrf_wr_decode #(.NREGS(NREGS), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .we_vec(we_vec), .wd_vec(wd_vec), .wr_odd_pair(wr_odd_pair)
  );

  dwrf_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_vec(we_vec), .wd_vec(wd_vec), .rf_q(rf_q)
  );

  dwrf_rd_port #(.NREGS(NREGS), .DW(DW), .PAIR_CAPABLE(1'b1)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rf_q(rf_q), .addr(ra_addr),
    .rd(op_a), .odd_pair(rd_odd_pair)
  );

  dwrf_rd_port #(.NREGS(NREGS), .DW(DW), .PAIR_CAPABLE(1'b0)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rf_q(rf_q), .addr(rb_addr),
    .rd(op_b), .odd_pair(b_unused_err)
  );

  assign pair_err = wr_odd_pair || rd_odd_pair || b_unused_err;

  // R5: both halves of a couple land on the same edge
  p_pair_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_pair_write(mode) && !wr_addr[0]) |=>
      (rf_q[$past(wr_addr)] == $past(wr_data[DW-1:0])) &&
      (rf_q[$past(wr_addr) + 1'b1] == $past(wr_data[2*DW-1:DW])));

  // R7: an odd couple write leaves the whole file untouched
  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_pair_write(mode) && wr_addr[0]) |=> $stable(rf_q));

  // R2: a byte write stores the low result byte
  p_byte_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_pair_write(mode)) |=>
      (rf_q[$past(wr_addr)] == $past(wr_data[DW-1:0])));

endmodule

// File: tb/tb_dwrf_core.sv
module tb_dwrf_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] op_a, op_b;
  logic        pair_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [32];

  always #4 clk = ~clk;

  dwrf_core dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ra_addr(ra_addr),
    .rb_addr(rb_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_a(op_a), .op_b(op_b), .pair_err(pair_err)
  );

  // {mode, wr_en, wr_addr, wr_data, ra, rb}
  localparam int NV = 20;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 1'b1, 5'd3,  16'hFFA5, 5'd3,  5'd0},
    {2'd0, 1'b1, 5'd31, 16'h003C, 5'd3,  5'd0},
    {2'd1, 1'b1, 5'd0,  16'h1111, 5'd31, 5'd3},
    {2'd1, 1'b1, 5'd7,  16'h2277, 5'd0,  5'd31},
    {2'd2, 1'b1, 5'd10, 16'hBEEF, 5'd7,  5'd3},
    {2'd1, 1'b0, 5'd12, 16'h9999, 5'd10, 5'd11},
    {2'd3, 1'b1, 5'd20, 16'hCAFE, 5'd10, 5'd0},
    {2'd3, 1'b0, 5'd0,  16'h0000, 5'd20, 5'd5},
    {2'd2, 1'b1, 5'd30, 16'h1234, 5'd20, 5'd21},
    {2'd3, 1'b1, 5'd2,  16'h5AA5, 5'd30, 5'd1},
    {2'd0, 1'b0, 5'd4,  16'h7777, 5'd31, 5'd2},
    {2'd1, 1'b1, 5'd21, 16'h00E1, 5'd2,  5'd3},
    {2'd3, 1'b0, 5'd0,  16'h0000, 5'd20, 5'd0},
    {2'd2, 1'b1, 5'd0,  16'h8001, 5'd21, 5'd30},
    {2'd3, 1'b1, 5'd6,  16'h0F0F, 5'd0,  5'd0},
    {2'd1, 1'b0, 5'd0,  16'h0000, 5'd6,  5'd7},
    {2'd3, 1'b1, 5'd31, 16'hDEAD, 5'd2,  5'd0},
    {2'd3, 1'b0, 5'd0,  16'h0000, 5'd9,  5'd0},
    {2'd2, 1'b1, 5'd17, 16'h4242, 5'd31, 5'd30},
    {2'd1, 1'b0, 5'd0,  16'h0000, 5'd16, 5'd17}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_a(input logic [1:0] m, input logic [4:0] ra);
    if (m == 2'd3) return ra[0] ? 16'h0 : {mdl[ra | 5'd1], mdl[ra]};
    return {8'h00, mdl[ra]};
  endfunction

  function automatic logic [15:0] exp_b(input logic [1:0] m, input logic [4:0] rb);
    if (m == 2'd1 || m == 2'd2) return {8'h00, mdl[rb]};
    return 16'h0;
  endfunction

  function automatic logic exp_err(input logic [1:0] m, input logic we,
                                   input logic [4:0] wa, input logic [4:0] ra);
    return (we && m[1] && wa[0]) || (m == 2'd3 && ra[0]);
  endfunction

  task automatic model_write(input logic [1:0] m, input logic we,
                             input logic [4:0] wa, input logic [15:0] wd);
    if (!we) return;
    if (m[1]) begin
      if (!wa[0]) begin
        mdl[wa] = wd[7:0];
        mdl[wa | 5'd1] = wd[15:8];
      end
    end else begin
      mdl[wa] = wd[7:0];
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic we, input logic [4:0] wa,
                       input logic [15:0] wd, input logic [4:0] ra,
                       input logic [4:0] rb, input string tag);
    @(negedge clk);
    mode_sel = m; wr_en = we; wr_addr = wa; wr_data = wd;
    ra_addr = ra; rb_addr = rb;
    #2;
    check({tag, " op_a"}, 32'(op_a), 32'(exp_a(m, ra)));
    check({tag, " op_b"}, 32'(op_b), 32'(exp_b(m, rb)));
    check({tag, " pair_err"}, 32'(pair_err), 32'(exp_err(m, we, wa, ra)));
    @(posedge clk);
    model_write(m, we, wa, wd);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    #20;
    // R1: reset state, read all registers in two-byte mode
    for (int i = 0; i < 32; i += 2) begin
      mode_sel = 2'd1; ra_addr = 5'(i); rb_addr = 5'(i + 1);
      #1;
      check("R1 reset a", 32'(op_a), 32'h0);
      check("R1 reset b", 32'(op_b), 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][33:32], VEC[v][31], VEC[v][30:26], VEC[v][25:10],
            VEC[v][9:5], VEC[v][4:0], "R2/R3/R4/R5/R6/R7/R9 vec");
    end

    // R8: byte write and read to same register, old value seen before edge
    apply(2'd0, 1'b1, 5'd12, 16'h0055, 5'd12, 5'd0, "R2 seed");
    apply(2'd1, 1'b1, 5'd12, 16'h00AA, 5'd12, 5'd12, "R8 same-cycle byte");
    apply(2'd1, 1'b0, 5'd0, 16'h0, 5'd12, 5'd0, "R8 after edge");
    // R8: couple write and couple read of same index
    apply(2'd3, 1'b1, 5'd14, 16'h6688, 5'd14, 5'd0, "R8 same-cycle pair");
    apply(2'd3, 1'b0, 5'd0, 16'h0, 5'd14, 5'd0, "R6 pair readback");
    // explicit value checks independent of model
    @(negedge clk); mode_sel = 2'd3; wr_en = 1'b0; ra_addr = 5'd14; #2;
    check("R5 pair halves", 32'(op_a), 32'h6688);

    // R7: odd couple write leaves neighbours untouched
    apply(2'd2, 1'b1, 5'd13, 16'hFFFF, 5'd12, 5'd14, "R7 odd write");
    @(negedge clk); mode_sel = 2'd1; wr_en = 1'b0; ra_addr = 5'd13; rb_addr = 5'd12; #2;
    check("R7 odd write reg13", 32'(op_a), 32'(mdl[13]));
    check("R7 odd write reg12", 32'(op_b), 32'h00AA);
    // R7: odd couple read returns zero
    @(negedge clk); mode_sel = 2'd3; ra_addr = 5'd15; #2;
    check("R7 odd read zero", 32'(op_a), 32'h0);
    check("R7 odd read flag", 32'(pair_err), 32'h1);

    // R9: disabled write sweeps every address, nothing changes
    for (int i = 0; i < 32; i++)
      apply(2'd0, 1'b0, 5'(i), 16'hA5A5, 5'(i), 5'd0, "R9 idle");

    // R1: asynchronous reset clears populated file
    @(negedge clk); rst_n = 1'b0; #1;
    for (int i = 0; i < 32; i++) begin
      mode_sel = 2'd0; ra_addr = 5'(i); #1;
      check("R1 reset clears", 32'(op_a), 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule